// File: doc/BRIEF.md
# Embedded-Sync 4:2:2 Video Word Generator

This block drives the byte-wide data input of a video encoder chip running as a timing slave. On every tick of the word clock it emits one byte of a 4:2:2 stream. In the default configuration that clock runs at 27 MHz, twice the 13.5 MHz pixel rate, because every pixel costs two bytes. The block keeps a word counter and a line counter over a 525-line interlaced frame of two fields. There are no separate sync wires. Horizontal, vertical and field timing reach the encoder only as four-byte timing codes written into the data stream. One code marks the end of each active line and another marks the start of the next one.

During the active part of a viewable line the block fetches pixel pairs through a simple request/valid port. It sends each pair as chroma-blue, luma, chroma-red, luma. Each request goes out a fixed number of cycles ahead of the word that needs the data. The codes 0x00 and 0xFF are reserved for timing codes, so incoming pixel bytes are clamped into 0x01..0xFE. Outside active video the block sends the neutral blanking pattern. If a pair does not arrive in time, the block sends blanking in its place and flags an underflow.

Default geometry: 858 pixel periods per line (1716 words), of which 720 pixels are active, and 525 lines, of which 487 are viewable. All of these figures are parameters.

Top module: `bt656_gen`

## Requirements
- R1: While `rst` is high, `vid_data` is 0x10 and both `fb_req` and `vid_underflow` are 0. The first four words after release are the end-of-active code of line 0.
- R2: A line is 2*PIX_PER_LINE words long and a frame is LINES lines long. Each line begins at word 0 with the end-of-active code 0xFF, 0x00, 0x00, XY. `vid_data` shows the word of a counter position one clock after the counter holds that position.
- R3: The code's last byte is XY = {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 first. H is 1 in the end-of-active code and 0 in the start-of-active code.
- R4: The start-of-active code 0xFF, 0x00, 0x00, XY sits at the four words just before ACT_START = 2*PIX_PER_LINE - 2*ACTIVE_PIX. The active samples run from ACT_START to the end of the line.
- R5: Every word that is neither a timing code nor an active sample is blanking: 0x80 at even word positions and 0x10 at odd ones. This covers the active region of lines with V=1.
- R6: Each delivered pair `fb_data` is sent over four consecutive words: bits [31:24] (Cb), then [23:16] (first Y), then [15:8] (Cr), then [7:0] (second Y). Pair k starts at word ACT_START+4k.
- R7: A pixel byte of 0x00 goes out as 0x01 and a byte of 0xFF goes out as 0xFE. No other byte value is altered.
- R8: With a zero-based line number ln, F is 0 when FLD0_FIRST <= ln < FLD1_FIRST and 1 otherwise. V is 1 when ln < VB0_END or VB1_FIRST <= ln < VB1_END.
- R9: On V=0 lines, `fb_req` is high for exactly one cycle, LEAD cycles before the cycle in which the counter reaches the Cb word of pair k. At that time `fb_pair` is k and `fb_line` is the current line. There is no request on V=1 lines.
- R10: A pair is taken only if `fb_valid` is high in a cycle after its request and before the Cb cycle. Otherwise the four words are 0x80, 0x10, 0x80, 0x10, and `vid_underflow` is high for the single clock in which the blank Cb word is on `vid_data`.
- R11: A `fb_valid` pulse is ignored when no request is outstanding, and also when it arrives in the Cb cycle of its pair. Such a pulse never fills a later pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_req | output | 1 | One-cycle pixel-pair fetch request |
| fb_line | output | $clog2(LINES) | Line number for the request |
| fb_pair | output | $clog2(ACTIVE_PIX/2) | Pair index within the line for the request |
| fb_valid | input | 1 | Returned pair is valid this cycle |
| fb_data | input | 32 | Returned pair {Cb, Y0, Cr, Y1} |
| vid_data | output | 8 | Video word stream to the encoder |
| vid_underflow | output | 1 | Pulses with a Cb word replaced because data was late |

## Verification
The bound checker checks the following on every cycle: each 0xFF is followed by two zero bytes and a well-formed protection byte, 0x00 appears only inside a timing code, the word counter wraps at the line length, requests are single-cycle pulses, and every underflow pulse lines up with a blank chroma byte. The exact placement of the codes, the F and V values for each line, the sample order, the clamping of reserved values, and the difference between a missing, a late and a stray response can be shown only by the bench. It replays whole frames of a small raster against an arithmetic model, while its memory model sweeps the response latency and withholds or delays chosen pairs.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

   localparam logic [7:0] BLANK_C = 8'h80;
   localparam logic [7:0] BLANK_Y = 8'h10;
   localparam logic [7:0] CODE_HI = 8'hFF;
   localparam logic [7:0] CODE_LO = 8'h00;

   // protection byte of a timing code
   function automatic logic [7:0] code_xy(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   // word idx (0..3) of a four-byte timing code
   function automatic logic [7:0] code_word(input int idx, input logic [7:0] xy);
      logic [7:0] w;
      case (idx)
         0:       w = CODE_HI;
         1, 2:    w = CODE_LO;
         default: w = xy;
      endcase
      return w;
   endfunction

   // keep reserved code values out of the sample data
   function automatic logic [7:0] clamp_sample(input logic [7:0] b);
      logic [7:0] r;
      if (b == 8'h00)      r = 8'h01;
      else if (b == 8'hFF) r = 8'hFE;
      else                 r = b;
      return r;
   endfunction

endpackage

// File: rtl/bt656_raster.sv
module bt656_raster #(
   parameter int WORDS      = 1716,
   parameter int LINES      = 525,
   parameter int FLD0_FIRST = 3,
   parameter int FLD1_FIRST = 265,
   parameter int VB0_END    = 19,
   parameter int VB1_FIRST  = 263,
   parameter int VB1_END    = 282,
   parameter int HW         = $clog2(WORDS),
   parameter int LW         = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [HW-1:0] h_pos,
   output logic [LW-1:0] line,
   output logic          fld,
   output logic          vbl
);

   localparam logic [HW-1:0] H_LAST = HW'(WORDS - 1);
   localparam logic [LW-1:0] L_LAST = LW'(LINES - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         h_pos <= '0;
         line  <= '0;
      end else if (h_pos == H_LAST) begin
         h_pos <= '0;
         line  <= (line == L_LAST) ? '0 : line + 1'b1;
      end else begin
         h_pos <= h_pos + 1'b1;
      end
   end

   always_comb begin
      fld = !(int'(line) >= FLD0_FIRST && int'(line) < FLD1_FIRST);
      vbl = (int'(line) < VB0_END) ||
            (int'(line) >= VB1_FIRST && int'(line) < VB1_END);
   end

endmodule

// File: rtl/bt656_fetch.sv
module bt656_fetch
   import bt656_pkg::*;
#(
   parameter int WORDS = 1716,
   parameter int ACT_W = 1440,
   parameter int LEAD  = 4,
   parameter int HW    = $clog2(WORDS),
   parameter int LW    = 10,
   parameter int PW    = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [HW-1:0] h_pos,
   input  logic [LW-1:0] line,
   input  logic          vbl,
   input  logic          fb_valid,
   input  logic [31:0]   fb_data,
   output logic          fb_req,
   output logic [LW-1:0] fb_line,
   output logic [PW-1:0] fb_pair,
   output logic          take,
   output logic          pair_ok,
   output logic [31:0]   pair_word
);

   localparam int ACT_START = WORDS - ACT_W;

   int          rel_req;
   int          rel_cur;
   logic        pending;
   logic        have;
   logic        capture;
   logic [31:0] held;
   logic [31:0] clamped;

   always_comb begin
      rel_req = int'(h_pos) + LEAD - ACT_START;
      rel_cur = int'(h_pos) - ACT_START;
   end

   assign fb_req  = !vbl && rel_req >= 0 && rel_req < ACT_W && (rel_req & 3) == 0;
   assign fb_pair = PW'(rel_req >> 2);
   assign fb_line = line;
   assign take    = !vbl && rel_cur >= 0 && (rel_cur & 3) == 0;
   assign capture = fb_valid && pending && !take;

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign clamped[g*8 +: 8] = clamp_sample(fb_data[g*8 +: 8]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pending <= 1'b0;
         have    <= 1'b0;
         held    <= '0;
      end else begin
         if (capture) held <= clamped;
         have    <= (have && !take) || capture;
         pending <= fb_req || (pending && !take && !capture);
      end
   end

   assign pair_ok   = have;
   assign pair_word = held;

endmodule

// File: rtl/bt656_format.sv
module bt656_format
   import bt656_pkg::*;
#(
   parameter int WORDS = 1716,
   parameter int ACT_W = 1440,
   parameter int HW    = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [HW-1:0] h_pos,
   input  logic          fld,
   input  logic          vbl,
   input  logic          take,
   input  logic          pair_ok,
   input  logic [31:0]   pair_word,
   output logic [7:0]    vid_data,
   output logic          vid_underflow
);

   localparam int ACT_START = WORDS - ACT_W;
   localparam int SAV_START = ACT_START - 4;
   localparam logic [23:0] BLANK_TAIL = {BLANK_Y, BLANK_C, BLANK_Y};

   int          hi;
   logic [7:0]  word;
   logic        uf;
   logic [23:0] tail;
   logic [23:0] tail_n;

   always_comb begin
      hi     = int'(h_pos);
      word   = h_pos[0] ? BLANK_Y : BLANK_C;
      uf     = 1'b0;
      tail_n = tail;
      if (hi < 4) begin
         word = code_word(hi, code_xy(fld, vbl, 1'b1));
      end else if (hi >= SAV_START && hi < ACT_START) begin
         word = code_word(hi - SAV_START, code_xy(fld, vbl, 1'b0));
      end else if (take) begin
         if (pair_ok) begin
            word   = pair_word[31:24];
            tail_n = pair_word[23:0];
         end else begin
            word   = BLANK_C;
            tail_n = BLANK_TAIL;
            uf     = 1'b1;
         end
      end else if (hi >= ACT_START && !vbl) begin
         case (h_pos[1:0])
            2'd1:    word = tail[23:16];
            2'd2:    word = tail[15:8];
            2'd3:    word = tail[7:0];
            default: word = BLANK_C;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vid_data      <= BLANK_Y;
         vid_underflow <= 1'b0;
         tail          <= BLANK_TAIL;
      end else begin
         vid_data      <= word;
         vid_underflow <= uf;
         tail          <= tail_n;
      end
   end

endmodule

// File: rtl/bt656_gen.sv
module bt656_gen #(
   parameter int PIX_PER_LINE = 858,
   parameter int ACTIVE_PIX   = 720,
   parameter int LINES        = 525,
   parameter int FLD0_FIRST   = 3,
   parameter int FLD1_FIRST   = 265,
   parameter int VB0_END      = 19,
   parameter int VB1_FIRST    = 263,
   parameter int VB1_END      = 282,
   parameter int LEAD         = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   output logic                            fb_req,
   output logic [$clog2(LINES)-1:0]        fb_line,
   output logic [$clog2(ACTIVE_PIX/2)-1:0] fb_pair,
   input  logic                            fb_valid,
   input  logic [31:0]                     fb_data,
   output logic [7:0]                      vid_data,
   output logic                            vid_underflow
);

   localparam int WORDS = 2 * PIX_PER_LINE;
   localparam int ACT_W = 2 * ACTIVE_PIX;
   localparam int HW    = $clog2(WORDS);
   localparam int LW    = $clog2(LINES);
   localparam int PW    = $clog2(ACTIVE_PIX / 2);

   if (PIX_PER_LINE % 2 != 0) begin : g_bad_ppl
      $error("PIX_PER_LINE must be even");
   end
   if (ACTIVE_PIX % 2 != 0 || ACTIVE_PIX < 4) begin : g_bad_act
      $error("ACTIVE_PIX must be even and at least 4");
   end
   if (WORDS - ACT_W < 8) begin : g_bad_blank
      $error("horizontal blanking too short for two timing codes");
   end
   if (LEAD < 2 || LEAD > 4) begin : g_bad_lead
      $error("LEAD must lie in 2..4");
   end
   if (!(FLD0_FIRST < FLD1_FIRST && FLD1_FIRST <= LINES &&
         VB0_END <= VB1_FIRST && VB1_FIRST <= VB1_END && VB1_END <= LINES)) begin : g_bad_lines
      $error("field or vertical blanking ranges out of order");
   end

   logic [HW-1:0] h_pos;
   logic [LW-1:0] line;
   logic          fld;
   logic          vbl;
   logic          take;
   logic          pair_ok;
   logic [31:0]   pair_word;

   bt656_raster #(
      .WORDS(WORDS), .LINES(LINES),
      .FLD0_FIRST(FLD0_FIRST), .FLD1_FIRST(FLD1_FIRST),
      .VB0_END(VB0_END), .VB1_FIRST(VB1_FIRST), .VB1_END(VB1_END),
      .HW(HW), .LW(LW)
   ) u_raster (
      .clk(clk), .rst(rst), .h_pos(h_pos), .line(line), .fld(fld), .vbl(vbl)
   );

   bt656_fetch #(
      .WORDS(WORDS), .ACT_W(ACT_W), .LEAD(LEAD), .HW(HW), .LW(LW), .PW(PW)
   ) u_fetch (
      .clk(clk), .rst(rst), .h_pos(h_pos), .line(line), .vbl(vbl),
      .fb_valid(fb_valid), .fb_data(fb_data),
      .fb_req(fb_req), .fb_line(fb_line), .fb_pair(fb_pair),
      .take(take), .pair_ok(pair_ok), .pair_word(pair_word)
   );

   bt656_format #(
      .WORDS(WORDS), .ACT_W(ACT_W), .HW(HW)
   ) u_format (
      .clk(clk), .rst(rst), .h_pos(h_pos), .fld(fld), .vbl(vbl),
      .take(take), .pair_ok(pair_ok), .pair_word(pair_word),
      .vid_data(vid_data), .vid_underflow(vid_underflow)
   );

endmodule

// File: rtl/bt656_gen_chk.sv
module bt656_gen_chk #(
   parameter int WORDS = 1716,
   parameter int HW    = $clog2(WORDS)
) (
   input logic          clk,
   input logic          rst,
   input logic [HW-1:0] h_pos,
   input logic [7:0]    vid_data,
   input logic          fb_req,
   input logic          vid_underflow
);

   localparam logic [HW-1:0] H_LAST = HW'(WORDS - 1);

   AST_CODE_SECOND: assert property (@(posedge clk) disable iff (rst)
      vid_data == 8'hFF |=> vid_data == 8'h00);  // R2

   AST_CODE_THIRD: assert property (@(posedge clk) disable iff (rst)
      ($past(vid_data) == 8'hFF && vid_data == 8'h00) |=> vid_data == 8'h00);  // R2

   AST_CODE_XY: assert property (@(posedge clk) disable iff (rst)
      ($past(vid_data, 3) == 8'hFF && $past(vid_data, 2) == 8'h00 && $past(vid_data) == 8'h00)
      |-> (vid_data[7] && vid_data[3:0] == {vid_data[5] ^ vid_data[4], vid_data[6] ^ vid_data[4],
                                           vid_data[6] ^ vid_data[5], ^vid_data[6:4]}));  // R3

   AST_ZERO_ONLY_IN_CODE: assert property (@(posedge clk) disable iff (rst)
      vid_data == 8'h00 |-> ($past(vid_data) == 8'hFF || $past(vid_data, 2) == 8'hFF));  // R7

   AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
      h_pos == H_LAST |=> h_pos == '0);  // R2

   AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
      h_pos != H_LAST |=> h_pos == $past(h_pos) + 1'b1);  // R2

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
      fb_req |=> !fb_req);  // R9

   AST_UFLOW_BLANK: assert property (@(posedge clk) disable iff (rst)
      vid_underflow |-> vid_data == 8'h80);  // R10

   AST_UFLOW_PULSE: assert property (@(posedge clk) disable iff (rst)
      vid_underflow |=> !vid_underflow);  // R10

endmodule

bind bt656_gen bt656_gen_chk #(
   .WORDS(2 * PIX_PER_LINE), .HW($clog2(2 * PIX_PER_LINE))
) i_chk (
   .clk(clk), .rst(rst), .h_pos(h_pos), .vid_data(vid_data),
   .fb_req(fb_req), .vid_underflow(vid_underflow)
);

// File: tb/test_bt656_gen.sv
module test_bt656_gen;

   localparam int PPL  = 16;
   localparam int AP   = 8;
   localparam int NL   = 10;
   localparam int F0F  = 1;
   localparam int F1F  = 6;
   localparam int VB0E = 2;
   localparam int VB1F = 5;
   localparam int VB1E = 7;
   localparam int LD   = 3;
   localparam int TW   = 2 * PPL;
   localparam int AW   = 2 * AP;
   localparam int AS   = TW - AW;
   localparam int SS   = AS - 4;
   localparam int NCYC = 2 * TW * NL;
   localparam int LW   = $clog2(NL);
   localparam int PW   = $clog2(AP / 2);

   logic          clk = 1'b0;
   logic          rst;
   logic          fb_req;
   logic [LW-1:0] fb_line;
   logic [PW-1:0] fb_pair;
   logic          fb_valid;
   logic [31:0]   fb_data;
   logic [7:0]    vid_data;
   logic          vid_underflow;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   bt656_gen #(
      .PIX_PER_LINE(PPL), .ACTIVE_PIX(AP), .LINES(NL),
      .FLD0_FIRST(F0F), .FLD1_FIRST(F1F),
      .VB0_END(VB0E), .VB1_FIRST(VB1F), .VB1_END(VB1E), .LEAD(LD)
   ) i_bt656_gen (
      .clk(clk), .rst(rst), .fb_req(fb_req), .fb_line(fb_line), .fb_pair(fb_pair),
      .fb_valid(fb_valid), .fb_data(fb_data),
      .vid_data(vid_data), .vid_underflow(vid_underflow)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit f_of(input int l);
      return !(l >= F0F && l < F1F);
   endfunction

   function automatic bit v_of(input int l);
      return (l < VB0E) || (l >= VB1F && l < VB1E);
   endfunction

   function automatic logic [7:0] xy_of(input bit f, input bit v, input bit h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   // byte j of pair k on line l: 0 Cb, 1 Y0, 2 Cr, 3 Y1
   function automatic logic [7:0] raw(input int l, input int k, input int j);
      if (k == 1) return (j % 2 == 0) ? 8'h00 : 8'hFF;
      return 8'((l * 29 + k * 53 + j * 71 + 5) % 256);
   endfunction

   function automatic logic [7:0] clampb(input logic [7:0] b);
      if (b == 8'h00) return 8'h01;
      if (b == 8'hFF) return 8'hFE;
      return b;
   endfunction

   function automatic logic [31:0] pack(input int l, input int k);
      return {raw(l, k, 0), raw(l, k, 1), raw(l, k, 2), raw(l, k, 3)};
   endfunction

   function automatic bit dropped(input int l, input int k);
      return (l == 4 && k == 0) || (l == 7 && k == 2);
   endfunction

   function automatic bit late(input int l, input int k);
      return l == 3 && k == 3;
   endfunction

   function automatic int lat(input int l);
      return 1 + (l % (LD - 1));
   endfunction

   task automatic exp_word(input int p, output logic [7:0] w, output bit uf, output string tag);
      int hp;
      int lp;
      int k;
      int ph;
      bit f;
      bit v;
      hp  = p % TW;
      lp  = (p / TW) % NL;
      f   = f_of(lp);
      v   = v_of(lp);
      uf  = 1'b0;
      w   = (hp % 2 == 0) ? 8'h80 : 8'h10;
      tag = "R5 blanking";
      if (hp < 4) begin
         w   = (hp == 0) ? 8'hFF : (hp == 3) ? xy_of(f, v, 1'b1) : 8'h00;
         tag = (hp == 3) ? "R3 R8 end code XY" : "R2 end code";
      end else if (hp >= SS && hp < AS) begin
         w   = (hp == SS) ? 8'hFF : (hp == AS - 1) ? xy_of(f, v, 1'b0) : 8'h00;
         tag = (hp == AS - 1) ? "R3 R8 start code XY" : "R4 start code";
      end else if (hp >= AS && !v) begin
         k  = (hp - AS) / 4;
         ph = (hp - AS) % 4;
         if (!dropped(lp, k) && !late(lp, k)) begin
            w   = clampb(raw(lp, k, ph));
            tag = (k == 1) ? "R7 clamp" : "R6 active order";
         end else begin
            w   = (ph % 2 == 0) ? 8'h80 : 8'h10;
            uf  = (ph == 0);
            tag = (late(lp, k) || (lp == 4 && k == 0)) ? "R11 ignored response" : "R10 underflow";
         end
      end
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0]  w;
      bit          uf;
      string       tag;
      bit          busy;
      int          cnt;
      logic [31:0] mdata;
      busy     = 1'b0;
      cnt      = 0;
      mdata    = '0;
      rst      = 1'b1;
      fb_valid = 1'b0;
      fb_data  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(vid_data == 8'h10, "R1 reset data", vid_data, 8'h10);
      chk(fb_req == 1'b0, "R1 reset request", fb_req, 0);
      chk(vid_underflow == 1'b0, "R1 reset underflow", vid_underflow, 0);
      rst = 1'b0;
      for (int n = 1; n <= NCYC; n++) begin
         int h;
         int l;
         int rel;
         bit req_e;
         @(negedge clk);
         h = n % TW;
         l = (n / TW) % NL;
         exp_word(n - 1, w, uf, tag);
         if (n <= 4) tag = {"R1 first words ", tag};
         chk(vid_data == w, tag, vid_data, w);
         chk(vid_underflow == uf, uf ? tag : "R10 no spurious underflow", vid_underflow, uf);
         rel   = h + LD - AS;
         req_e = !v_of(l) && rel >= 0 && rel < AW && (rel % 4) == 0;
         chk(fb_req == req_e, "R9 request timing", fb_req, req_e);
         if (req_e && fb_req) begin
            chk(int'(fb_pair) == rel / 4, "R9 pair index", fb_pair, rel / 4);
            chk(int'(fb_line) == l, "R9 line number", fb_line, l);
         end
         // memory model: respond L cycles after the request
         fb_valid = 1'b0;
         if (busy) begin
            if (cnt == 0) begin
               fb_valid = 1'b1;
               fb_data  = mdata;
               busy     = 1'b0;
            end else begin
               cnt--;
            end
         end
         if (l == 4 && h == 8 && !busy) begin
            fb_valid = 1'b1;  // R11 stray response with nothing outstanding
            fb_data  = 32'h11223344;
         end
         if (fb_req) begin
            int k;
            int lq;
            k  = int'(fb_pair);
            lq = int'(fb_line);
            if (!dropped(lq, k)) begin
               busy  = 1'b1;
               cnt   = (late(lq, k) ? LD : lat(lq)) - 1;
               mdata = pack(lq, k);
            end
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule